// File: doc/BRIEF.md
# Serial PCM Line Encoding Transmitter

This block turns a stream of bytes into a single line-coded serial signal. Bytes written through a small FIFO are moved one at a time into a shift register and sent MSB first. Each bit then passes through a line encoder that the host picks from a 3-bit code select. The choices are three NRZ variants, three bi-phase variants and Miller. An encoder enable lets software bypass the coder. With a bi-phase or Miller code selected, the bypassed raw bits are sent one per half bit period, so software can put pre-encoded half-bit pairs into the FIFO.

All timing comes from `half_tick_i`, a one-cycle strobe given twice per line bit period. A line bit spans two strobes, and a raw bit in two-level bypass spans one. The enable and the code select are captured only when a byte moves from the FIFO into the shift register. A changed setting therefore never splits a byte. An optional synchronisation clock marks the bit periods of NRZ traffic.

Top module: `pcm_line_tx`

## Requirements
- R1: After reset, `line_o` is 0, `sync_clk_o` is 0, `fifo_empty_o` is 1 and `fifo_full_o` is 0. The Miller history bit is 0.
- R2: The FIFO holds DEPTH bytes and raises `fifo_full_o` when it is full. A write while full is dropped, and that byte is never sent.
- R3: `fifo_empty_o` rises on the clock edge at which the last stored byte moves into the shift register, while that byte is still being sent.
- R4: Bytes go out MSB first. A coded or NRZ bit occupies two consecutive `half_tick_i` strobes. The next byte is loaded on the strobe after the last bit ends, with no gap, while the FIFO holds data.
- R5: Code select `000` is NRZ-level: line = bit. `001` is NRZ-mark: the line toggles at bit start on a 1. `010` is NRZ-space: the line toggles at bit start on a 0.
- R6: `011` is bi-phase-level: 1 is sent as high then low, and 0 as low then high. `100` is bi-phase-mark and `101` is bi-phase-space. Both always toggle at bit start. Mark toggles again mid-bit on a 1, and space toggles again mid-bit on a 0.
- R7: `110` and `111` are Miller. The line toggles mid-bit on a 1. It toggles at bit start only when the current bit and the previous Miller bit are both 0.
- R8: With `enc_en_i` = 0 the line equals the raw bit. With an NRZ code, a raw bit lasts two strobes. With any other code, a raw bit lasts one strobe.
- R9: `enc_en_i` and `code_i` are sampled only at a byte load. Changes during a byte have no effect on that byte.
- R10: While the FIFO and the shift register are empty, `line_o` holds its last level and strobes have no effect.
- R11: `sync_clk_o` is high during the first half and low during the second half of each bit period. It is active only when `sync_en_i` is 1 and the byte's captured code is an NRZ code, coded or raw. It is low when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_tick_i | input | 1 | Strobe, two per line bit period |
| wr_i | input | 1 | FIFO write strobe |
| wr_data_i | input | DW | Byte to queue |
| enc_en_i | input | 1 | 1: encode, 0: bypass coder |
| code_i | input | 3 | Line code select |
| sync_en_i | input | 1 | Enables the bit sync clock |
| fifo_empty_o | output | 1 | FIFO holds no byte |
| fifo_full_o | output | 1 | FIFO holds DEPTH bytes |
| line_o | output | 1 | Encoded serial line |
| sync_clk_o | output | 1 | Bit synchronisation clock |

## Verification
The differential codes feed the current line level back into the coder. A wrong level or a wrong Miller history bit therefore inverts every later line half. The bench's per-strobe reference catches this within one strobe of the fault. A bit counter or phase that is off by one slips the MSB-first order or the half-bit alignment, and shows as a mismatch on the first affected strobe. A mode captured at the wrong moment changes the line within the byte that straddles the change.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam logic [2:0] CODE_NRZ_L = 3'b000;
  localparam logic [2:0] CODE_NRZ_M = 3'b001;
  localparam logic [2:0] CODE_NRZ_S = 3'b010;
  localparam logic [2:0] CODE_BP_L  = 3'b011;
  localparam logic [2:0] CODE_BP_M  = 3'b100;
  localparam logic [2:0] CODE_BP_S  = 3'b101;

  typedef struct packed {
    logic       enc_en;
    logic [2:0] code;
  } tx_mode_t;

  function automatic logic is_nrz(input logic [2:0] c);
    return c < 3'd3;
  endfunction

  function automatic logic is_miller(input logic [2:0] c);
    return c[2] & c[1];
  endfunction

  // raw bit per half strobe: bypass with a two-level code
  function automatic logic is_fast(input tx_mode_t m);
    return ~m.enc_en & ~is_nrz(m.code);
  endfunction
endpackage

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign wr_ok     = wr_i & ~full_o;
  assign rd_ok     = rd_i & ~empty_o;
  assign rd_data_o = mem_q[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_full_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_i && !rd_i |=> full_o && $stable(wp_q));

  a_r3_empty_on_last_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(1)) && rd_i && !wr_i |=> empty_o);
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_tick_i,
  input  logic          enc_en_i,
  input  logic [2:0]    code_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_data_i,
  output logic          pop_o,
  output logic          start_o,
  output logic          mid_o,
  output logic          bit_o,
  output tx_mode_t      mode_o,
  output tx_mode_t      held_mode_o,
  output logic          busy_o,
  output logic          first_half_o
);
  localparam int LW = $clog2(DW + 1);

  logic [DW-1:0] sr_q, word;
  logic [LW-1:0] left_q;
  logic          ph_q, busy_q, cur_q, slot;
  tx_mode_t      mode_q, mode_n;

  assign slot    = half_tick_i & ~ph_q;
  assign pop_o   = slot & (left_q == '0) & ~fifo_empty_i;
  assign start_o = slot & ((left_q != '0) | ~fifo_empty_i);
  assign mid_o   = half_tick_i & ph_q;
  assign mode_n  = pop_o ? tx_mode_t'{enc_en: enc_en_i, code: code_i} : mode_q;
  assign word    = pop_o ? fifo_data_i : sr_q;
  assign bit_o   = start_o ? word[DW-1] : cur_q;

  assign mode_o       = mode_n;
  assign held_mode_o  = mode_q;
  assign busy_o       = busy_q;
  assign first_half_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
      ph_q   <= 1'b0;
      busy_q <= 1'b0;
      cur_q  <= 1'b0;
      mode_q <= '0;
    end else if (start_o) begin
      sr_q   <= word << 1;
      left_q <= (pop_o ? LW'(DW) : left_q) - LW'(1);
      cur_q  <= word[DW-1];
      ph_q   <= ~is_fast(mode_n);
      busy_q <= 1'b1;
      mode_q <= mode_n;
    end else if (slot) begin
      busy_q <= 1'b0;
    end else if (mid_o) begin
      ph_q   <= 1'b0;
    end
  end

  a_r9_mode_held_in_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !pop_o |=> $stable(mode_q));

  a_r4_two_strobes_per_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !is_fast(mode_n) |=> ph_q && $stable(sr_q) || !half_tick_i);

  a_r8_fast_no_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && is_fast(mode_q) |-> !mid_o);
endmodule

// File: rtl/pcm_tx_coder.sv
module pcm_tx_coder
  import pcm_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  logic     mid_i,
  input  logic     bit_i,
  input  tx_mode_t mode_i,
  output logic     line_o
);
  logic lvl_q, lvl_n, prev_q, prev_n;

  always_comb begin
    lvl_n  = lvl_q;
    prev_n = prev_q;
    if (start_i) begin
      if (!mode_i.enc_en) begin
        lvl_n = bit_i;
      end else begin
        case (mode_i.code)
          CODE_NRZ_L, CODE_BP_L: lvl_n = bit_i;
          CODE_NRZ_M:            lvl_n = lvl_q ^ bit_i;
          CODE_NRZ_S:            lvl_n = lvl_q ^ ~bit_i;
          CODE_BP_M, CODE_BP_S:  lvl_n = ~lvl_q;
          default: begin
            lvl_n  = (~bit_i & ~prev_q) ? ~lvl_q : lvl_q;
            prev_n = bit_i;
          end
        endcase
      end
    end else if (mid_i && mode_i.enc_en) begin
      case (mode_i.code)
        CODE_BP_L: lvl_n = ~bit_i;
        CODE_BP_M: lvl_n = bit_i ? ~lvl_q : lvl_q;
        CODE_BP_S: lvl_n = bit_i ? lvl_q : ~lvl_q;
        default:   lvl_n = (is_miller(mode_i.code) && bit_i) ? ~lvl_q : lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_n;
      prev_q <= prev_n;
    end
  end

  assign line_o = lvl_q;

  a_r6_bpl_mid_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_i && mode_i.enc_en && (mode_i.code == CODE_BP_L) |=> line_o != $past(line_o));

  a_r6_bpms_start_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mode_i.enc_en && (mode_i.code == CODE_BP_M || mode_i.code == CODE_BP_S)
    |=> line_o != $past(line_o));

  a_r7_miller_one_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_i && mode_i.enc_en && is_miller(mode_i.code) && bit_i |=> line_o != $past(line_o));

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !mid_i |=> $stable(line_o));
endmodule

// File: rtl/pcm_line_tx.sv
module pcm_line_tx
  import pcm_tx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          half_tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          enc_en_i,
  input  logic [2:0]    code_i,
  input  logic          sync_en_i,
  output logic          fifo_empty_o,
  output logic          fifo_full_o,
  output logic          line_o,
  output logic          sync_clk_o
);
  logic [DW-1:0] fifo_data;
  logic          pop, start, mid, cur_bit, busy, first_half;
  tx_mode_t      mode, held_mode;

  pcm_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .rd_i      (pop),
    .rd_data_o (fifo_data),
    .empty_o   (fifo_empty_o),
    .full_o    (fifo_full_o)
  );

  pcm_tx_serializer #(.DW(DW)) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .half_tick_i  (half_tick_i),
    .enc_en_i     (enc_en_i),
    .code_i       (code_i),
    .fifo_empty_i (fifo_empty_o),
    .fifo_data_i  (fifo_data),
    .pop_o        (pop),
    .start_o      (start),
    .mid_o        (mid),
    .bit_o        (cur_bit),
    .mode_o       (mode),
    .held_mode_o  (held_mode),
    .busy_o       (busy),
    .first_half_o (first_half)
  );

  pcm_tx_coder u_coder (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .mid_i   (mid),
    .bit_i   (cur_bit),
    .mode_i  (mode),
    .line_o  (line_o)
  );

  assign sync_clk_o = sync_en_i & busy & first_half & is_nrz(held_mode.code);

  a_r11_sync_rises_with_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_clk_o) |-> $past(start) || $rose(sync_en_i));

  a_r11_sync_only_nrz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clk_o |-> busy && !is_fast(held_mode));
endmodule

// File: tb/tb_pcm_line_tx.sv
module tb_pcm_line_tx;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       half_tick_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       enc_en_i = 1'b1;
  logic [2:0] code_i = 3'b000;
  logic       sync_en_i = 1'b0;
  logic       fifo_empty_o, fifo_full_o, line_o, sync_clk_o;

  pcm_line_tx #(.DW(8), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_tick_i(half_tick_i), .wr_i(wr_i),
    .wr_data_i(wr_data_i), .enc_en_i(enc_en_i), .code_i(code_i),
    .sync_en_i(sync_en_i), .fifo_empty_o(fifo_empty_o), .fifo_full_o(fifo_full_o),
    .line_o(line_o), .sync_clk_o(sync_clk_o)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string tag = "R1";
  bit    tick_run = 1'b0;
  int    div = 0;

  // reference model state
  logic [7:0] fq[$];
  bit         hl[$];
  bit         hf[$];
  bit         m_line = 0, m_first = 0, m_nrz = 0, m_prev = 0;

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic gen_byte(input logic [7:0] b);
    bit lvl, s, m, x;
    lvl = m_line;
    m_nrz = (code_i < 3'd3);
    for (int i = 7; i >= 0; i--) begin
      x = b[i];
      if (!enc_en_i) begin
        if (m_nrz) begin hl.push_back(x); hf.push_back(1); hl.push_back(x); hf.push_back(0); end
        else begin hl.push_back(x); hf.push_back(0); end
      end else begin
        case (code_i)
          3'd0: begin s = x; m = s; end
          3'd1: begin s = lvl ^ x; m = s; end
          3'd2: begin s = lvl ^ ~x; m = s; end
          3'd3: begin s = x; m = ~x; end
          3'd4: begin s = ~lvl; m = x ? ~s : s; end
          3'd5: begin s = ~lvl; m = x ? s : ~s; end
          default: begin s = (!x && !m_prev) ? ~lvl : lvl; m = x ? ~s : s; m_prev = x; end
        endcase
        hl.push_back(s); hf.push_back(1); hl.push_back(m); hf.push_back(0);
        lvl = m;
      end
    end
  endtask

  always @(posedge clk) begin
    bit acc;
    cyc++;
    if (!rst_ni) begin
      fq.delete(); hl.delete(); hf.delete();
      m_line = 0; m_first = 0; m_nrz = 0; m_prev = 0;
    end else begin
      acc = wr_i && (fq.size() < DEPTH);
      if (half_tick_i) begin
        if (hl.size() == 0 && fq.size() > 0) gen_byte(fq.pop_front());
        if (hl.size() > 0) begin
          m_line  = hl.pop_front();
          m_first = hf.pop_front();
        end else m_first = 0;
      end
      if (acc) fq.push_back(wr_data_i);
      #5;
      chk(tag, line_o, m_line, "line_o");
      chk("R11", sync_clk_o, sync_en_i & m_first & m_nrz, "sync_clk_o");
      chk("R3", fifo_empty_o, fq.size() == 0, "fifo_empty_o");
      chk("R2", fifo_full_o, fq.size() == DEPTH, "fifo_full_o");
    end
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (tick_run) begin
      div = (div == 2) ? 0 : div + 1;
      half_tick_i = (div == 0);
    end else half_tick_i = 1'b0;
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_i = 1'b1; wr_data_i = b;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic drain();
    while (fq.size() != 0 || hl.size() != 0) @(negedge clk);
    repeat (9) @(negedge clk);
  endtask

  task automatic mode(input logic en, input logic [2:0] c);
    @(negedge clk); enc_en_i = en; code_i = c;
  endtask

  task automatic run_code(input string t, input logic en, input logic [2:0] c,
                          input logic [7:0] a, input logic [7:0] b);
    tag = t;
    mode(en, c);
    put(a); put(b);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", line_o, 1'b0, "line_o reset");
    chk("R1", sync_clk_o, 1'b0, "sync reset");
    chk("R1", fifo_empty_o, 1'b1, "empty reset");
    chk("R1", fifo_full_o, 1'b0, "full reset");
    rst_ni = 1'b1;
    tick_run = 1'b1;
    repeat (4) @(negedge clk);

    run_code("R4", 1, 3'd0, 8'hA5, 8'h3C);
    run_code("R5", 1, 3'd1, 8'hB2, 8'h0F);
    run_code("R5", 1, 3'd2, 8'h6D, 8'hF0);
    run_code("R6", 1, 3'd3, 8'h9A, 8'h01);
    run_code("R6", 1, 3'd4, 8'hC3, 8'h55);
    run_code("R6", 1, 3'd5, 8'h71, 8'hAE);
    run_code("R7", 1, 3'd6, 8'h00, 8'hF0);
    run_code("R7", 1, 3'd7, 8'h93, 8'h4B);
    run_code("R8", 0, 3'd0, 8'hE6, 8'h19);
    run_code("R8", 0, 3'd4, 8'h96, 8'h69);
    run_code("R8", 0, 3'd6, 8'hA5, 8'h3C);

    // R9: change settings mid-byte
    tag = "R9";
    mode(1, 3'd0);
    put(8'hD4); put(8'h2B);
    repeat (12) @(negedge clk);
    mode(1, 3'd3);
    repeat (9) @(negedge clk);
    mode(0, 3'd1);
    drain();

    // R2: fill while stopped, overflow byte dropped
    tag = "R2";
    tick_run = 1'b0;
    mode(1, 3'd1);
    for (int i = 0; i < DEPTH + 1; i++) put(8'h11 * i[7:0] + 8'h21);
    @(negedge clk);
    chk("R2", fifo_full_o, 1'b1, "full after DEPTH writes");
    tick_run = 1'b1;
    drain();

    // R3: single byte, empty while it is sent
    tag = "R3";
    put(8'h5A);
    while (hl.size() == 0) @(negedge clk);
    chk("R3", fifo_empty_o, 1'b1, "empty while last byte sends");
    drain();

    // R10: idle strobes hold the line
    tag = "R10";
    repeat (30) @(negedge clk);
    chk("R10", line_o, m_line, "idle hold");

    // R11: sync clock with NRZ coded, NRZ raw, bi-phase
    tag = "R11";
    sync_en_i = 1'b1;
    run_code("R11", 1, 3'd2, 8'hC5, 8'h3A);
    run_code("R11", 0, 3'd0, 8'h81, 8'h7E);
    run_code("R11", 1, 3'd5, 8'h0F, 8'hF0);
    sync_en_i = 1'b0;
    repeat (5) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule